// File: doc/BRIEF.md
# Two-Dimensional Strided Burst Address Generator

This block turns one committed transfer descriptor into a series of per-row burst requests for a single memory-side port. A descriptor carries a start address, a row length, a row count, a row stride, a transfer tag, a repeat flag and a flag telling whether the port is memory-mapped or streaming. Row length and row count are both written as the real value minus one. For every row the block presents the row's base address and length on a valid/ready request stream. After each accepted row it moves the base forward by the stride. The stride is independent of the row length, so gaps between rows are allowed. A row count field of zero gives a plain one-dimensional transfer.

When the last row is accepted, the block sends a one-cycle completion pulse carrying the tag. In repeat mode it then starts again at the first row and never retires the descriptor, pulsing completion at the end of every pass. An abort input drops whatever is in progress and returns the block to idle. The current row address is always visible so that software-facing logic can read it back.

Top module: `stride_burst_gen`

## Requirements
- R1: After reset `descReady` is 1, `reqValid` and `doneValid` are 0, and `curAddr` is 0.
- R2: A descriptor is taken on a clock edge where `descValid` and `descReady` are both 1. The first request is valid in the next cycle. `descReady` stays 0 while requests are being issued, and `descReady` and `reqValid` are never both 1.
- R3: A descriptor with row-count field Y produces exactly Y+1 accepted requests. Each request's `reqLen` equals the descriptor's row-length field, which is bytes minus one.
- R4: On a memory-mapped side, row k has address A + k*S modulo 2^ADDR_W. A and S are the descriptor address and stride with their low ALIGN_LOG2 bits forced to zero, so every request address has those bits zero.
- R5: A row-count field of 0 gives a single request followed by completion.
- R6: While `reqValid` is 1 and `reqReady` is 0, `reqAddr` and `reqLen` hold their values and the request stays valid.
- R7: `doneValid` is 1 for exactly one cycle: the cycle after the last row's request is accepted. `doneId` then equals the descriptor's tag. No pulse occurs at any other time.
- R8: With `descCyclic` set, the request after the last row returns to row 0's address. A completion pulse follows every pass, and `descReady` stays 0.
- R9: With `descIsMem` at 0 (streaming side), `reqAddr` and `curAddr` are 0 and the stride is ignored. Row count and row length still apply.
- R10: While `abort` is 1, `reqValid` and `descReady` are 0. In the cycle after, `reqValid` and `doneValid` are 0 and `descReady` is 1, and the dropped descriptor never signals completion. A request offered with `reqReady` in the abort cycle is not taken. A new descriptor is accepted normally afterwards.
- R11: `curAddr` equals the address of the row currently being requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| abort | input | 1 | Drop the current descriptor and go idle |
| descValid | input | 1 | Descriptor offered |
| descReady | output | 1 | Generator idle and able to take a descriptor |
| descAddr | input | ADDR_W | First row address |
| descXLen | input | LEN_W | Row length in bytes minus one |
| descYLen | input | ROWS_W | Row count minus one |
| descStride | input | ADDR_W | Address step between row starts |
| descId | input | ID_W | Transfer tag returned on completion |
| descCyclic | input | 1 | Repeat the descriptor forever |
| descIsMem | input | 1 | 1 when the port is memory-mapped, 0 when streaming |
| reqValid | output | 1 | Row request valid |
| reqReady | input | 1 | Row request accepted |
| reqAddr | output | ADDR_W | Row start address |
| reqLen | output | LEN_W | Row length in bytes minus one |
| doneValid | output | 1 | One-cycle completion pulse |
| doneId | output | ID_W | Tag of the completed descriptor |
| curAddr | output | ADDR_W | Current row address |

## Verification
A wrong row counter shows up at the very next accepted request. Either completion arrives one row early or late, or an extra request with a wrong address appears. The sweeps compare every row's address, length and completion timing, so such a fault is caught within one row of where it starts. A fault in stride accumulation or masking appears at the second row as a wrong address. A broken stall, repeat or abort path appears in the cycle right after the triggering stimulus: as a changed request under back-pressure, a missing return to row 0, or a stray completion pulse.

// File: rtl/sbg_pkg.sv
package sbg_pkg;
  typedef enum logic {
    ST_IDLE,
    ST_ISSUE
  } sbg_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic advance;
    logic rewind;
  } sbg_strobe_t;
endpackage

// File: rtl/sbg_dpath.sv
module sbg_dpath
  import sbg_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int ROWS_W     = 12,
  parameter int ID_W       = 5,
  parameter int ALIGN_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  sbg_strobe_t       strb,
  input  logic [ADDR_W-1:0] descAddr,
  input  logic [LEN_W-1:0]  descXLen,
  input  logic [ROWS_W-1:0] descYLen,
  input  logic [ADDR_W-1:0] descStride,
  input  logic [ID_W-1:0]   descId,
  input  logic              descCyclic,
  input  logic              descIsMem,
  output logic              lastRow,
  output logic              cyclic,
  output logic [ADDR_W-1:0] rowAddr,
  output logic [LEN_W-1:0]  rowLen,
  output logic [ID_W-1:0]   tagId
);
  localparam logic [ADDR_W-1:0] LOW_ONES   = ADDR_W'((64'd1 << ALIGN_LOG2) - 64'd1);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~LOW_ONES;

  logic [ADDR_W-1:0] baseQ, rowAddrQ, strideQ;
  logic [LEN_W-1:0]  xLenQ;
  logic [ROWS_W-1:0] yLastQ, rowCntQ;
  logic [ID_W-1:0]   idQ;
  logic              cyclicQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ    <= '0;
      rowAddrQ <= '0;
      strideQ  <= '0;
      xLenQ    <= '0;
      yLastQ   <= '0;
      rowCntQ  <= '0;
      idQ      <= '0;
      cyclicQ  <= 1'b0;
    end else if (strb.load) begin
      baseQ    <= descIsMem ? (descAddr & ALIGN_MASK) : '0;
      rowAddrQ <= descIsMem ? (descAddr & ALIGN_MASK) : '0;
      strideQ  <= descIsMem ? (descStride & ALIGN_MASK) : '0;
      xLenQ    <= descXLen;
      yLastQ   <= descYLen;
      rowCntQ  <= '0;
      idQ      <= descId;
      cyclicQ  <= descCyclic;
    end else if (strb.rewind) begin
      rowAddrQ <= baseQ;
      rowCntQ  <= '0;
    end else if (strb.advance) begin
      rowAddrQ <= rowAddrQ + strideQ;
      rowCntQ  <= rowCntQ + 1'b1;
    end
  end

  assign lastRow = (rowCntQ == yLastQ);
  assign cyclic  = cyclicQ;
  assign rowAddr = rowAddrQ;
  assign rowLen  = xLenQ;
  assign tagId   = idQ;
endmodule

// File: rtl/sbg_ctrl.sv
module sbg_ctrl
  import sbg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        abort,
  input  logic        descValid,
  input  logic        reqReady,
  input  logic        lastRow,
  input  logic        cyclic,
  output logic        descReady,
  output logic        reqValid,
  output logic        doneValid,
  output sbg_strobe_t strb
);
  sbg_state_t stateQ, stateNext;
  logic       doneQ, doneNext;

  always_comb begin
    strb      = '0;
    stateNext = stateQ;
    doneNext  = 1'b0;
    descReady = (stateQ == ST_IDLE) && !abort;
    reqValid  = (stateQ == ST_ISSUE) && !abort;
    if (abort) begin
      stateNext = ST_IDLE;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (descValid) begin
            strb.load = 1'b1;
            stateNext = ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (reqReady) begin
            if (lastRow) begin
              doneNext = 1'b1;
              if (cyclic) strb.rewind = 1'b1;
              else        stateNext   = ST_IDLE;
            end else begin
              strb.advance = 1'b1;
            end
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateNext;
      doneQ  <= doneNext;
    end
  end

  assign doneValid = doneQ;
endmodule

// File: rtl/stride_burst_gen.sv
module stride_burst_gen
  import sbg_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int ROWS_W     = 12,
  parameter int ID_W       = 5,
  parameter int ALIGN_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              abort,
  input  logic              descValid,
  output logic              descReady,
  input  logic [ADDR_W-1:0] descAddr,
  input  logic [LEN_W-1:0]  descXLen,
  input  logic [ROWS_W-1:0] descYLen,
  input  logic [ADDR_W-1:0] descStride,
  input  logic [ID_W-1:0]   descId,
  input  logic              descCyclic,
  input  logic              descIsMem,
  output logic              reqValid,
  input  logic              reqReady,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [LEN_W-1:0]  reqLen,
  output logic              doneValid,
  output logic [ID_W-1:0]   doneId,
  output logic [ADDR_W-1:0] curAddr
);
  sbg_strobe_t       strb;
  logic              lastRow, cyclic;
  logic [ADDR_W-1:0] rowAddr;

  sbg_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .abort     (abort),
    .descValid (descValid),
    .reqReady  (reqReady),
    .lastRow   (lastRow),
    .cyclic    (cyclic),
    .descReady (descReady),
    .reqValid  (reqValid),
    .doneValid (doneValid),
    .strb      (strb)
  );

  sbg_dpath #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .ROWS_W(ROWS_W),
    .ID_W(ID_W), .ALIGN_LOG2(ALIGN_LOG2)
  ) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .descAddr   (descAddr),
    .descXLen   (descXLen),
    .descYLen   (descYLen),
    .descStride (descStride),
    .descId     (descId),
    .descCyclic (descCyclic),
    .descIsMem  (descIsMem),
    .lastRow    (lastRow),
    .cyclic     (cyclic),
    .rowAddr    (rowAddr),
    .rowLen     (reqLen),
    .tagId      (doneId)
  );

  assign reqAddr = rowAddr;
  assign curAddr = rowAddr;
endmodule

// File: rtl/sbg_checker.sv
module sbg_checker #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int ALIGN_LOG2 = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              abort,
  input logic              descReady,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [LEN_W-1:0]  reqLen,
  input logic              doneValid
);
  localparam logic [ADDR_W-1:0] LOW_ONES = ADDR_W'((64'd1 << ALIGN_LOG2) - 64'd1);

  p_busy_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(descReady && reqValid));

  p_addr_align_r4: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> ((reqAddr & LOW_ONES) == '0));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady && !abort) |=> (reqValid && $stable(reqAddr) && $stable(reqLen)));

  p_done_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> $past(reqValid && reqReady));

  p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    abort |=> (!reqValid && !doneValid));
endmodule

bind stride_burst_gen sbg_checker #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .ALIGN_LOG2(ALIGN_LOG2)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .abort     (abort),
  .descReady (descReady),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .reqAddr   (reqAddr),
  .reqLen    (reqLen),
  .doneValid (doneValid)
);

// File: tb/stride_burst_gen_tb_top.sv
`timescale 1ns/1ps
module stride_burst_gen_tb_top;
  localparam int AW = 16;
  localparam int LW = 8;
  localparam int RW = 3;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          abort = 1'b0;
  logic          descValid = 1'b0;
  logic          descReady;
  logic [AW-1:0] descAddr = '0;
  logic [LW-1:0] descXLen = '0;
  logic [RW-1:0] descYLen = '0;
  logic [AW-1:0] descStride = '0;
  logic [IW-1:0] descId = '0;
  logic          descCyclic = 1'b0;
  logic          descIsMem = 1'b1;
  logic          reqValid;
  logic          reqReady = 1'b0;
  logic [AW-1:0] reqAddr;
  logic [LW-1:0] reqLen;
  logic          doneValid;
  logic [IW-1:0] doneId;
  logic [AW-1:0] curAddr;

  int nChecks = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  stride_burst_gen #(
    .ADDR_W(AW), .LEN_W(LW), .ROWS_W(RW), .ID_W(IW), .ALIGN_LOG2(2)
  ) dut_i (
    .clk(clk), .rstN(rstN), .abort(abort),
    .descValid(descValid), .descReady(descReady),
    .descAddr(descAddr), .descXLen(descXLen), .descYLen(descYLen),
    .descStride(descStride), .descId(descId), .descCyclic(descCyclic),
    .descIsMem(descIsMem),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr), .reqLen(reqLen),
    .doneValid(doneValid), .doneId(doneId), .curAddr(curAddr)
  );

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] rowExp(input logic [AW-1:0] a, input logic [AW-1:0] st,
                                          input int r, input logic mem);
    logic [AW-1:0] s;
    s = st & ~16'h3;
    return mem ? AW'((a & ~16'h3) + AW'(r) * s) : '0;
  endfunction

  // passes == 0: one-shot descriptor; passes > 0: cyclic, left running
  task automatic runDesc(input logic [AW-1:0] a, input logic [LW-1:0] xl, input logic [RW-1:0] yl,
                         input logic [AW-1:0] st, input logic [IW-1:0] id, input logic mem,
                         input logic pat, input int passes);
    logic [AW-1:0] e;
    int nPass;
    nPass = (passes == 0) ? 1 : passes;
    check(descReady === 1'b1, "R2 ready before descriptor", descReady, 1);
    descAddr = a; descXLen = xl; descYLen = yl; descStride = st; descId = id;
    descCyclic = (passes != 0); descIsMem = mem; descValid = 1'b1;
    @(negedge clk);
    descValid = 1'b0;
    for (int p = 0; p < nPass; p++) begin
      for (int r = 0; r <= int'(yl); r++) begin
        e = rowExp(a, st, r, mem);
        if (pat && (r % 2 == 1)) begin
          reqReady = 1'b0;
          @(negedge clk);
          check(reqValid === 1'b1, "R6 valid held under stall", reqValid, 1);
          check(reqAddr === e, "R6 address held under stall", reqAddr, e);
        end
        check(reqValid === 1'b1, "R3 row request valid", reqValid, 1);
        check(reqAddr === e, mem ? (p > 0 ? "R8 address after wrap" : "R4 row address")
                                 : "R9 streaming address", reqAddr, e);
        check(reqLen === xl, "R3 row length", reqLen, xl);
        check(curAddr === e, "R11 current address", curAddr, e);
        check(descReady === 1'b0, passes != 0 ? "R8 busy in repeat" : "R2 busy", descReady, 0);
        reqReady = 1'b1;
        @(negedge clk);
        reqReady = 1'b0;
        if (r == int'(yl)) begin
          check(doneValid === 1'b1, yl == 0 ? "R5 single row done" :
                (passes != 0 ? "R8 pass done" : "R7 done pulse"), doneValid, 1);
          check(doneId === id, "R7 done tag", doneId, id);
        end else begin
          check(doneValid === 1'b0, "R7 no early done", doneValid, 0);
        end
      end
    end
    if (passes == 0) begin
      check(reqValid === 1'b0, yl == 0 ? "R5 one request only" : "R3 no extra request", reqValid, 0);
      check(descReady === 1'b1, "R2 idle after last row", descReady, 1);
      @(negedge clk);
      check(doneValid === 1'b0, "R7 pulse one cycle", doneValid, 0);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    nChecks++;
    nFail++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    logic [RW-1:0] ylSet[5];
    logic [AW-1:0] stSet[4];
    ylSet = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd7};
    stSet = '{16'h0004, 16'h0014, 16'h0107, 16'hFFF0};
    repeat (3) @(negedge clk);
    check(descReady === 1'b1, "R1 reset ready", descReady, 1);
    check(reqValid === 1'b0, "R1 reset request", reqValid, 0);
    check(doneValid === 1'b0, "R1 reset done", doneValid, 0);
    check(curAddr === '0, "R1 reset address", curAddr, 0);
    rstN = 1'b1;
    @(negedge clk);

    // memory-mapped sweep over rows, strides and back-pressure
    for (int yi = 0; yi < 5; yi++)
      for (int si = 0; si < 4; si++)
        for (int pt = 0; pt < 2; pt++)
          runDesc(AW'(16'h1003 + yi * 16'h0111), LW'(8'h0F + yi * 8'h10), ylSet[yi],
                  stSet[si], IW'(yi * 8 + si * 2 + pt), 1'b1, pt[0], 0);

    // streaming side ignores address and stride
    runDesc(16'h4444, 8'h3F, 3'd2, 16'h0100, 5'd21, 1'b0, 1'b1, 0);
    runDesc(16'h8888, 8'h07, 3'd0, 16'h0020, 5'd22, 1'b0, 1'b0, 0);

    // repeat mode, three passes, then abort
    runDesc(16'h2000, 8'h1F, 3'd2, 16'h0040, 5'd9, 1'b1, 1'b1, 3);
    check(reqValid === 1'b1, "R8 repeat continues", reqValid, 1);
    check(reqAddr === 16'h2000, "R8 restart at row 0", reqAddr, 16'h2000);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    #1;
    check(reqValid === 1'b0, "R10 abort stops requests", reqValid, 0);
    check(descReady === 1'b1, "R10 abort returns idle", descReady, 1);
    check(doneValid === 1'b0, "R10 no done on abort", doneValid, 0);

    // abort mid one-shot descriptor while the request is offered
    descAddr = 16'h3000; descXLen = 8'h03; descYLen = 3'd3; descStride = 16'h0010;
    descId = 5'd30; descCyclic = 1'b0; descIsMem = 1'b1; descValid = 1'b1;
    @(negedge clk);
    descValid = 1'b0;
    reqReady = 1'b1;
    @(negedge clk);
    check(reqAddr === 16'h3010, "R4 second row before abort", reqAddr, 16'h3010);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    reqReady = 1'b0;
    #1;
    check(reqValid === 1'b0, "R10 partial descriptor dropped", reqValid, 0);
    check(doneValid === 1'b0, "R10 no done after partial", doneValid, 0);
    check(curAddr === 16'h3010, "R10 request in abort cycle not taken", curAddr, 16'h3010);
    @(negedge clk);
    check(doneValid === 1'b0, "R10 no late done", doneValid, 0);
    runDesc(16'h5000, 8'h0B, 3'd1, 16'h0200, 5'd31, 1'b1, 1'b0, 0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule